// File: doc/BRIEF.md
# Nack-Cycle Deadlock Detector

Each core of a multiprocessor keeps a detector that spots a ring of cores blocking each other with nacks. Such a ring means that an access reordering, which would have broken sequential consistency, was stopped before it could happen. The detector watches two local facts. The first is that the core is currently nacking a coherence request from outside. The second is that the core's own oldest outstanding request is itself being nacked by some other core. When both hold at once, the detector arms. While armed, it tags every retry message the core sends with a bitmap that has one bit per core, and with a false-sharing flag. It folds every tag it receives into its own.

The ring is closed when a tag comes back that already holds this core's bit. In that cycle the detector emits a one-cycle rollback command naming a single victim core, chosen in a fixed way. Unless the cycle came only from false sharing, it also emits a log record holding the conflicting addresses and the PC. The core then undoes and re-executes its reordered accesses while the rest of the machine carries on. No timestamps are used at any point.

Top module: `nack_cycle_detector`

## Requirements
- R1: After synchronous reset the detector is idle: `tx_valid`, `rollback_valid` and `log_valid` are 0.
- R2: The detector arms on the clock edge where `nack_active` and `oldest_nacked` are both 1. From the next cycle `tx_valid` is 1 and `tx_map` holds only bit `SELF_ID`. Either condition alone never arms it.
- R3: While armed, a received tag (`rx_valid`=1) without bit `SELF_ID` is ORed into the map, and its `rx_fs` is ORed into `tx_fs`. Both are visible on the next cycle.
- R4: If either arming condition is 0 at a clock edge while armed, the next cycle shows `tx_valid`=0 and the bitmap is cleared. A later arming starts again from the own bit alone.
- R5: While armed, a received tag that contains bit `SELF_ID` closes the cycle. On the next cycle `rollback_valid` is 1 for exactly one cycle and `tx_valid` is 0.
- R6: The log record is captured at the moment of arming and presented during closure. It holds the address of the nacked external request (`log_ext_addr`), and the address and PC of the own oldest request (`log_own_addr`, `log_own_pc`).
- R7: `rollback_core` is the index of the lowest-numbered bit set in the union of the own map and the closing tag.
- R8: Local false sharing exists when `nack_ext_addr` and `held_addr` differ in any bit at or above bit `WORD_LSB` (default 2, i.e. 4-byte words). If local or any received false sharing is flagged, closure still rolls back but `log_valid` stays 0. Otherwise `log_valid` is 1 together with `rollback_valid`.
- R9: A received tag while idle has no effect: no arming, no rollback, no log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nack_active | input | 1 | This core is nacking an external coherence request |
| nack_ext_addr | input | ADDR_W | Address of the external request being nacked |
| held_addr | input | ADDR_W | Address of the local reordered access that caused the nack |
| oldest_nacked | input | 1 | Own oldest outstanding request is nacked by another core |
| own_addr | input | ADDR_W | Address of own oldest request |
| own_pc | input | PC_W | PC of own oldest request |
| rx_valid | input | 1 | A retry tag was received |
| rx_map | input | NUM_CORES | Received core bitmap |
| rx_fs | input | 1 | Received false-sharing flag |
| tx_valid | output | 1 | Outgoing retries must carry the tag |
| tx_map | output | NUM_CORES | Outgoing core bitmap |
| tx_fs | output | 1 | Outgoing false-sharing flag |
| rollback_valid | output | 1 | One-cycle rollback command |
| rollback_core | output | $clog2(NUM_CORES) | Victim core index |
| log_valid | output | 1 | Log record valid (true consistency violation) |
| log_ext_addr | output | ADDR_W | Logged external address |
| log_own_addr | output | ADDR_W | Logged own address |
| log_own_pc | output | PC_W | Logged own PC |

## Verification
Arming is tried with each condition alone, with both together, and with a received tag while idle. These patterns separate a correct AND of the conditions from an OR, and show that idle traffic is ignored. Rings are closed with tags that place other bits above, below and at the core's own index, which checks the merge, the closure test and the lowest-index victim choice. Equal and differing word addresses, together with a false-sharing flag arriving from outside, show whether the log is suppressed while rollback still happens. A dropped condition followed by a re-arm shows that a stale bitmap does not survive.

// File: rtl/ndd_pkg.sv
package ndd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_CLOSED = 2'd2
    } det_state_e;

    typedef enum logic [1:0] {
        MAP_HOLD  = 2'd0,
        MAP_SEED  = 2'd1,
        MAP_MERGE = 2'd2,
        MAP_CLEAR = 2'd3
    } map_op_e;
endpackage

// File: rtl/ndd_tag_reg.sv
module ndd_tag_reg
    import ndd_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int SELF_ID   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  map_op_e              op,
    input  logic                 seed_fs,
    input  logic [NUM_CORES-1:0] in_map,
    input  logic                 in_fs,
    output logic [NUM_CORES-1:0] map_q,
    output logic                 fs_q
);
    localparam logic [NUM_CORES-1:0] SELF_BIT = NUM_CORES'(1) << SELF_ID;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
            fs_q  <= 1'b0;
        end else begin
            unique case (op)
                MAP_SEED: begin
                    map_q <= SELF_BIT;
                    fs_q  <= seed_fs;
                end
                MAP_MERGE: begin
                    map_q <= map_q | in_map;
                    fs_q  <= fs_q | in_fs;
                end
                MAP_CLEAR: begin
                    map_q <= '0;
                    fs_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R3
    merge_keeps_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (op == MAP_MERGE) |=> ((map_q & $past(in_map)) == $past(in_map)));
endmodule

// File: rtl/ndd_victim_sel.sv
module ndd_victim_sel #(
    parameter int NUM_CORES = 16,
    localparam int IDW      = $clog2(NUM_CORES)
) (
    input  logic [NUM_CORES-1:0] map,
    output logic [IDW-1:0]       victim
);
    always_comb begin
        victim = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (map[i]) victim = IDW'(i);
        end
    end
endmodule

// File: rtl/ndd_capture.sv
module ndd_capture #(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] d_ext,
    input  logic [ADDR_W-1:0] d_own,
    input  logic [PC_W-1:0]   d_pc,
    output logic [ADDR_W-1:0] q_ext,
    output logic [ADDR_W-1:0] q_own,
    output logic [PC_W-1:0]   q_pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_ext <= '0;
            q_own <= '0;
            q_pc  <= '0;
        end else if (load) begin
            q_ext <= d_ext;
            q_own <= d_own;
            q_pc  <= d_pc;
        end
    end
endmodule

// File: rtl/nack_cycle_detector.sv
module nack_cycle_detector
    import ndd_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int SELF_ID   = 5,
    parameter int ADDR_W    = 32,
    parameter int PC_W      = 32,
    parameter int WORD_LSB  = 2,
    localparam int IDW      = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 nack_active,
    input  logic [ADDR_W-1:0]    nack_ext_addr,
    input  logic [ADDR_W-1:0]    held_addr,
    input  logic                 oldest_nacked,
    input  logic [ADDR_W-1:0]    own_addr,
    input  logic [PC_W-1:0]      own_pc,
    input  logic                 rx_valid,
    input  logic [NUM_CORES-1:0] rx_map,
    input  logic                 rx_fs,
    output logic                 tx_valid,
    output logic [NUM_CORES-1:0] tx_map,
    output logic                 tx_fs,
    output logic                 rollback_valid,
    output logic [IDW-1:0]       rollback_core,
    output logic                 log_valid,
    output logic [ADDR_W-1:0]    log_ext_addr,
    output logic [ADDR_W-1:0]    log_own_addr,
    output logic [PC_W-1:0]      log_own_pc
);
    det_state_e           state_q, state_d;
    map_op_e              map_op;
    logic                 both_hold;
    logic                 local_fs;
    logic                 own_bit_back;
    logic [NUM_CORES-1:0] map_q;
    logic                 fs_q;

    assign both_hold    = nack_active && oldest_nacked;
    assign local_fs     = nack_ext_addr[ADDR_W-1:WORD_LSB] != held_addr[ADDR_W-1:WORD_LSB];
    assign own_bit_back = rx_valid && rx_map[SELF_ID];

    always_comb begin
        state_d = state_q;
        map_op  = MAP_HOLD;
        unique case (state_q)
            ST_IDLE: begin
                if (both_hold) begin
                    state_d = ST_ARMED;
                    map_op  = MAP_SEED;
                end
            end
            ST_ARMED: begin
                if (!both_hold) begin
                    state_d = ST_IDLE;
                    map_op  = MAP_CLEAR;
                end else if (rx_valid) begin
                    map_op = MAP_MERGE;
                    if (own_bit_back) state_d = ST_CLOSED;
                end
            end
            ST_CLOSED: begin
                state_d = ST_IDLE;
                map_op  = MAP_CLEAR;
            end
            default: begin
                state_d = ST_IDLE;
                map_op  = MAP_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    ndd_tag_reg #(.NUM_CORES(NUM_CORES), .SELF_ID(SELF_ID)) u_tag (
        .clk(clk), .rst(rst), .op(map_op), .seed_fs(local_fs),
        .in_map(rx_map), .in_fs(rx_fs), .map_q(map_q), .fs_q(fs_q)
    );

    ndd_victim_sel #(.NUM_CORES(NUM_CORES)) u_victim (
        .map(map_q), .victim(rollback_core)
    );

    ndd_capture #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_cap (
        .clk(clk), .rst(rst), .load(map_op == MAP_SEED),
        .d_ext(nack_ext_addr), .d_own(own_addr), .d_pc(own_pc),
        .q_ext(log_ext_addr), .q_own(log_own_addr), .q_pc(log_own_pc)
    );

    assign tx_valid       = (state_q == ST_ARMED);
    assign tx_map         = map_q;
    assign tx_fs          = fs_q;
    assign rollback_valid = (state_q == ST_CLOSED);
    assign log_valid      = (state_q == ST_CLOSED) && !fs_q;

    // R5
    rollback_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rollback_valid |=> !rollback_valid);
    // R8
    log_needs_rollback_chk: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> rollback_valid);
    // R4
    drop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !(nack_active && oldest_nacked)) |=> !tx_valid);
    // R2
    arm_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> ($past(nack_active && oldest_nacked) && $onehot(tx_map) && tx_map[SELF_ID]));
    // R7
    victim_in_map_chk: assert property (@(posedge clk) disable iff (rst)
        rollback_valid |-> (map_q[rollback_core] && map_q[SELF_ID]));
endmodule

// File: tb/nack_cycle_detector_test.sv
`timescale 1ns/1ps
module nack_cycle_detector_test;
    localparam int N    = 16;
    localparam int SELF = 5;

    typedef struct {
        int          victim;
        bit          logged;
        logic [31:0] ext_a;
        logic [31:0] own_a;
        logic [31:0] pc;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nack_active = 0, oldest_nacked = 0, rx_valid = 0, rx_fs = 0;
    logic [31:0] nack_ext_addr = 0, held_addr = 0, own_addr = 0, own_pc = 0;
    logic [N-1:0] rx_map = 0;
    logic tx_valid, tx_fs, rollback_valid, log_valid;
    logic [N-1:0] tx_map;
    logic [3:0] rollback_core;
    logic [31:0] log_ext_addr, log_own_addr, log_own_pc;

    int checks = 0, fails = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    nack_cycle_detector #(.NUM_CORES(N), .SELF_ID(SELF)) uut (
        .clk(clk), .rst(rst), .nack_active(nack_active), .nack_ext_addr(nack_ext_addr),
        .held_addr(held_addr), .oldest_nacked(oldest_nacked), .own_addr(own_addr),
        .own_pc(own_pc), .rx_valid(rx_valid), .rx_map(rx_map), .rx_fs(rx_fs),
        .tx_valid(tx_valid), .tx_map(tx_map), .tx_fs(tx_fs),
        .rollback_valid(rollback_valid), .rollback_core(rollback_core),
        .log_valid(log_valid), .log_ext_addr(log_ext_addr),
        .log_own_addr(log_own_addr), .log_own_pc(log_own_pc)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_rb(int v, bit lg, logic [31:0] e, logic [31:0] o, logic [31:0] p, string tag);
        exp_t it;
        it.victim = v; it.logged = lg; it.ext_a = e; it.own_a = o; it.pc = p; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic arm(logic [31:0] ext_a, logic [31:0] held, logic [31:0] o, logic [31:0] p);
        nack_active = 1; oldest_nacked = 1;
        nack_ext_addr = ext_a; held_addr = held; own_addr = o; own_pc = p;
        tick();
        // change inputs after arming: the log must keep captured values (R6)
        nack_ext_addr = 32'hDEAD_0000; own_addr = 32'hBEEF_0000; own_pc = 32'h0BAD_0000;
    endtask

    task automatic send(logic [N-1:0] m, logic fs);
        rx_valid = 1; rx_map = m; rx_fs = fs;
        tick();
        rx_valid = 0; rx_map = '0; rx_fs = 0;
    endtask

    task automatic release_all();
        nack_active = 0; oldest_nacked = 0;
    endtask

    // monitor: compare every rollback against the scoreboard
    always @(negedge clk) begin
        if (!rst && rollback_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5: unexpected rollback actual 1 expected 0");
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                chk({it.tag, " R7 victim"}, 64'(rollback_core), 64'(it.victim));
                chk({it.tag, " R8 log_valid"}, 64'(log_valid), 64'(it.logged));
                if (it.logged) begin
                    chk({it.tag, " R6 ext addr"}, 64'(log_ext_addr), 64'(it.ext_a));
                    chk({it.tag, " R6 own addr"}, 64'(log_own_addr), 64'(it.own_a));
                    chk({it.tag, " R6 own pc"}, 64'(log_own_pc), 64'(it.pc));
                end
            end
        end
    end

    initial begin
        #500000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        // R1
        chk("R1 tx_valid", 64'(tx_valid), 0);
        chk("R1 rollback_valid", 64'(rollback_valid), 0);
        chk("R1 log_valid", 64'(log_valid), 0);

        // R2: one condition alone never arms
        nack_active = 1; tick(); tick();
        chk("R2 nack only", 64'(tx_valid), 0);
        nack_active = 0; oldest_nacked = 1; tick(); tick();
        chk("R2 oldest only", 64'(tx_valid), 0);
        oldest_nacked = 0;

        // R9: tag in idle ignored
        send(16'h0020, 0);
        chk("R9 idle tag tx", 64'(tx_valid), 0);
        chk("R9 idle tag rollback", 64'(rollback_valid), 0);
        tick();
        chk("R9 idle tag later", 64'(rollback_valid), 0);

        // true conflict ring
        arm(32'h1000, 32'h1000, 32'h2000, 32'h400);
        chk("R2 armed", 64'(tx_valid), 1);
        chk("R2 seed map", 64'(tx_map), 64'h0020);
        chk("R8 seed fs", 64'(tx_fs), 0);
        send(16'h0200, 0);
        chk("R3 merged map", 64'(tx_map), 64'h0220);
        chk("R3 still armed", 64'(tx_valid), 1);
        expect_rb(3, 1, 32'h1000, 32'h2000, 32'h400, "ring1");
        send(16'h0028, 0);
        release_all();
        chk("R5 tx off at closure", 64'(tx_valid), 0);
        chk("R5 rollback on", 64'(rollback_valid), 1);
        tick();
        chk("R5 single pulse", 64'(rollback_valid), 0);

        // R4: drop then re-arm fresh
        arm(32'h3000, 32'h3000, 32'h3100, 32'h500);
        send(16'h8000, 1);
        chk("R3 fs merged", 64'(tx_fs), 1);
        oldest_nacked = 0;
        tick();
        chk("R4 dropped", 64'(tx_valid), 0);
        arm(32'h3000, 32'h3000, 32'h3100, 32'h500);
        chk("R4 fresh map", 64'(tx_map), 64'h0020);
        chk("R4 fresh fs", 64'(tx_fs), 0);
        expect_rb(0, 1, 32'h3000, 32'h3100, 32'h500, "ring2");
        send(16'h0021, 0);
        release_all();
        tick();

        // R8: local false sharing (different word, same line)
        arm(32'h4104, 32'h4100, 32'h4200, 32'h600);
        chk("R8 local fs flag", 64'(tx_fs), 1);
        expect_rb(5, 0, 0, 0, 0, "fs_local");
        send(16'h1020, 0);
        release_all();
        chk("R8 rollback despite fs", 64'(rollback_valid), 1);
        chk("R8 no log", 64'(log_valid), 0);
        tick();

        // R8: false sharing flagged by another core
        arm(32'h5000, 32'h5002, 32'h5100, 32'h700);
        chk("R8 same word not fs", 64'(tx_fs), 0);
        send(16'h0080, 1);
        expect_rb(5, 0, 0, 0, 0, "fs_remote");
        send(16'h0020, 0);
        release_all();
        tick(); tick();

        chk("R5 all rollbacks seen", 64'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule